// File: doc/BRIEF.md
# Block Erase Controller with Suspend and Resume

This block sequences a modelled block-erase algorithm for a memory divided into a fixed number of blocks, and lets software pause and continue that erase. Commands arrive already decoded: a strobe, a 4-bit opcode and a target block index. The erase is modelled as a run of equal segments, each `SEG_CYC` cycles long, with a checkpoint at the end of each. A pause request is held until the next checkpoint. While the erase is paused, only a restricted set of commands is taken. A program of any block other than the paused one may run to completion in that window. Resume is refused until that program has finished.

The block also runs single programs and blank checks from idle, and keeps a status byte. In that byte, bit 7 means ready, bit 6 means erase paused, bit 5 flags an erase or blank-check failure, bit 4 a program failure and bit 3 a supply-voltage failure. Bits 2..0 read as zero. Each error bit stays set until a clear command. The outputs are the status byte, copies of its ready and paused bits, the block the controller is working on, and the read mode that the last read command selected.

Top module: `erase_susp_ctrl`

## Requirements
- R1: After reset, status_o is 0x80, ready_o is 1, esusp_o is 0, busy_blk_o is 0 and read_mode_o is 0.
- R2: The opcodes are 1 read array, 2 read status, 3 read identifier, 4 read query, 5 clear status, 6 erase, 7 program, 8 suspend, 9 resume, 10 blank check, 11 program suspend, 12 lock, 13 unlock and 14 lock-down; 0 and 15 are undefined. Read commands in idle set read_mode_o to 0 (array), 1 (status), 2 (identifier) or 3 (query). An erase from idle drops status bit 7 on the strobe edge, shows the block on busy_blk_o, sets read_mode_o to 1, and finishes NCHK*SEG_CYC edges later with bit 7 set and busy_blk_o at 0.
- R3: Checkpoints fall every SEG_CYC edges after the erase starts. A suspend taken during an erase pauses it at the first checkpoint at or after the strobe edge, setting status bits 7 and 6. When that checkpoint is the last one, the erase completes and does not pause.
- R4: A resume while paused clears status bits 7 and 6 on its edge. The erase then finishes (NCHK - checkpoints already passed)*SEG_CYC edges later.
- R5: A program takes PROG_CYC edges. If it is issued while paused and aims at another block, status bit 7 is 0, bit 6 stays 1 and busy_blk_o shows that block. When it ends, the controller is paused again with bit 7 set.
- R6: While paused, a program aimed at the paused block sets status bit 4 and the controller stays paused. A read-array command aimed at the paused block leaves read_mode_o unchanged; one aimed at any other block sets it to 0.
- R7: While paused, erase, blank check, suspend, 0 and 15 are ignored. While an erase runs, only suspend is taken. While a program or blank check runs, every command is ignored.
- R8: A resume issued while a program runs inside a pause is ignored. The erase stays paused after the program ends.
- R9: Suspend and resume act the same whatever block index comes with them.
- R10: If vpp_ok is low on an edge while an erase runs, the erase stops on that edge. Status bits 3 and 5 are set, bit 7 returns to 1, and the block no longer counts as erased.
- R11: A blank check takes CHK_CYC edges. It sets status bit 5 when the block has been programmed since its last completed erase, or when its erase was halted. Every block counts as erased after reset.
- R12: Error bits 5, 4 and 3 stay set across other commands. Clear status, taken in idle or while paused, clears all three.
- R13: Reset returns the controller to the R1 state from any state, including a paused erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| cmd_blk | input | BLK_W | Target block index |
| vpp_ok | input | 1 | Programming supply is at a valid level |
| status_o | output | 8 | Status byte |
| ready_o | output | 1 | Status bit 7 |
| esusp_o | output | 1 | Status bit 6, erase paused |
| busy_blk_o | output | BLK_W | Block being erased, programmed or checked; 0 in idle |
| read_mode_o | output | 2 | Read mode selected by the last accepted read command |

## Verification
The bench issues the suspend at many offsets into the erase, including edges exactly on a checkpoint and edges just before the final checkpoint. A controller that paused at once, or one cycle late, shows bit 6 on the wrong edge. One that paused at the final checkpoint never completes. After each resume, the bench times the rest of the erase. A design that restarted the count, or skipped segments, finishes at the wrong edge. Inside the pause, random illegal commands and random program targets catch a controller that started a second erase, programmed the paused block, or let a resume cut short a program already running. Supply loss, blank-check results after program and erase, sticky errors and reset while paused are each driven directly.

// File: rtl/esc_pkg.sv
package esc_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_RD_ARRAY = 4'd1,
    OP_RD_STAT  = 4'd2,
    OP_RD_ID    = 4'd3,
    OP_RD_QUERY = 4'd4,
    OP_CLR      = 4'd5,
    OP_ERASE    = 4'd6,
    OP_PROG     = 4'd7,
    OP_SUSP     = 4'd8,
    OP_RESUME   = 4'd9,
    OP_BLANK    = 4'd10,
    OP_PSUSP    = 4'd11,
    OP_LOCK     = 4'd12,
    OP_UNLOCK   = 4'd13,
    OP_LOCKDN   = 4'd14,
    OP_RSVD     = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ERASE     = 3'd1,
    ST_PROG      = 3'd2,
    ST_BLANK     = 3'd3,
    ST_SUSP      = 3'd4,
    ST_SUSP_PROG = 3'd5
  } state_e;

  localparam logic [1:0] RM_ARRAY  = 2'd0;
  localparam logic [1:0] RM_STATUS = 2'd1;
  localparam logic [1:0] RM_ID     = 2'd2;
  localparam logic [1:0] RM_QUERY  = 2'd3;

  localparam int SR_RDY  = 7;
  localparam int SR_ESUS = 6;
  localparam int SR_EERR = 5;
  localparam int SR_PERR = 4;
  localparam int SR_VERR = 3;

  // Commands taken while an erase sits paused
  function automatic logic op_ok_in_susp(logic [3:0] op);
    case (op)
      OP_RD_ARRAY, OP_RD_STAT, OP_RD_ID, OP_RD_QUERY,
      OP_RESUME, OP_CLR, OP_PROG, OP_PSUSP,
      OP_LOCK, OP_UNLOCK, OP_LOCKDN: return 1'b1;
      default:                       return 1'b0;
    endcase
  endfunction

  function automatic logic is_read_op(logic [3:0] op);
    return (op == OP_RD_ARRAY) || (op == OP_RD_STAT) ||
           (op == OP_RD_ID)    || (op == OP_RD_QUERY);
  endfunction

  function automatic logic [1:0] read_mode_of(logic [3:0] op);
    case (op)
      OP_RD_STAT:  return RM_STATUS;
      OP_RD_ID:    return RM_ID;
      OP_RD_QUERY: return RM_QUERY;
      default:     return RM_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/esc_cmd_gate.sv
module esc_cmd_gate
  import esc_pkg::*;
#(
  parameter int BLK_W = 3
) (
  input  logic             valid,
  input  logic [3:0]       op,
  input  logic [BLK_W-1:0] blk,
  input  logic [BLK_W-1:0] susp_blk,
  input  state_e           state,
  output logic             acc_erase,
  output logic             acc_prog,
  output logic             acc_nest,
  output logic             prog_hit,
  output logic             acc_blank,
  output logic             acc_susp,
  output logic             acc_resume,
  output logic             acc_clr,
  output logic             acc_read,
  output logic [1:0]       rd_mode
);

  logic in_idle, in_susp, in_erase, legal, same_blk;

  assign in_idle  = (state == ST_IDLE);
  assign in_susp  = (state == ST_SUSP);
  assign in_erase = (state == ST_ERASE);
  assign same_blk = (blk == susp_blk);

  always_comb begin
    if (in_idle)       legal = 1'b1;
    else if (in_susp)  legal = op_ok_in_susp(op);
    else if (in_erase) legal = (op == OP_SUSP);
    else               legal = 1'b0;
  end

  logic take;
  assign take = valid && legal;

  assign acc_erase  = take && (op == OP_ERASE) && in_idle;
  assign acc_prog   = take && (op == OP_PROG) && in_idle;
  assign acc_nest   = take && (op == OP_PROG) && in_susp && !same_blk;
  assign prog_hit   = take && (op == OP_PROG) && in_susp && same_blk;
  assign acc_blank  = take && (op == OP_BLANK) && in_idle;
  assign acc_susp   = take && (op == OP_SUSP) && in_erase;
  assign acc_resume = take && (op == OP_RESUME) && in_susp;
  assign acc_clr    = take && (op == OP_CLR);
  assign acc_read   = take && is_read_op(op) &&
                      !(in_susp && (op == OP_RD_ARRAY) && same_blk);
  assign rd_mode    = read_mode_of(op);

endmodule

// File: rtl/esc_erase_seq.sv
module esc_erase_seq #(
  parameter int NCHK    = 4,
  parameter int SEG_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic resume,
  input  logic run,
  input  logic susp_cmd,
  output logic ckpt,
  output logic last_ckpt,
  output logic susp_take
);

  localparam int SEG_W = $clog2(SEG_CYC + 1);
  localparam int CHK_W = $clog2(NCHK + 1);
  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(SEG_CYC - 1);
  localparam logic [CHK_W-1:0] CHK_LAST = CHK_W'(NCHK - 1);
  localparam logic [CHK_W-1:0] CHK_MAX  = CHK_W'(NCHK);

  logic [SEG_W-1:0] seg_q;
  logic [CHK_W-1:0] chk_q;
  logic             pend_q;

  assign ckpt      = run && (seg_q == SEG_LAST);
  assign last_ckpt = ckpt && (chk_q == CHK_LAST);
  assign susp_take = ckpt && !last_ckpt && (pend_q || susp_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      chk_q <= '0;
    end else if (start) begin
      seg_q <= '0;
      chk_q <= '0;
    end else if (resume) begin
      seg_q <= '0;
    end else if (run) begin
      if (ckpt) begin
        seg_q <= '0;
        if (!last_ckpt) chk_q <= chk_q + 1'b1;
      end else begin
        seg_q <= seg_q + 1'b1;
      end
    end
  end

  // pause request held until the next checkpoint
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (!run)     pend_q <= 1'b0;
    else if (ckpt)     pend_q <= 1'b0;
    else if (susp_cmd) pend_q <= 1'b1;
  end

  a_r4_chk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    chk_q < CHK_MAX);

  a_r3_pend_dropped_at_ckpt: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt |=> !pend_q);

endmodule

// File: rtl/esc_op_timer.sv
module esc_op_timer #(
  parameter int MAXC = 5,
  localparam int TW = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  input  logic          run,
  output logic          done
);

  logic [TW-1:0] cnt_q;

  assign done = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= len - 1'b1;
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/esc_status.sv
module esc_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       susp,
  input  logic       set_eerr,
  input  logic       set_perr,
  input  logic       set_verr,
  input  logic       clr,
  output logic [7:0] sr
);

  logic [2:0] err_q;  // {erase/blank, program, voltage}

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else begin
      err_q <= (clr ? 3'b000 : err_q) | {set_eerr, set_perr, set_verr};
    end
  end

  assign sr = {ready, susp, err_q, 3'b000};

  a_r12_errs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_q & $past(err_q)) == $past(err_q)));

endmodule

// File: rtl/erase_susp_ctrl.sv
module erase_susp_ctrl
  import esc_pkg::*;
#(
  parameter int NUM_BLK  = 8,
  parameter int NCHK     = 4,
  parameter int SEG_CYC  = 6,
  parameter int PROG_CYC = 5,
  parameter int CHK_CYC  = 3,
  localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             vpp_ok,
  output logic [7:0]       status_o,
  output logic             ready_o,
  output logic             esusp_o,
  output logic [BLK_W-1:0] busy_blk_o,
  output logic [1:0]       read_mode_o
);

  localparam int MAXC = (PROG_CYC > CHK_CYC) ? PROG_CYC : CHK_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] PROG_LEN  = TW'(PROG_CYC);
  localparam logic [TW-1:0] BLANK_LEN = TW'(CHK_CYC);

  state_e           state_q, state_n;
  logic [BLK_W-1:0] eblk_q, pblk_q;
  logic [NUM_BLK-1:0] blank_q;
  logic [1:0]       rmode_q;

  // named internal events
  logic acc_erase, acc_prog, acc_nest, prog_hit, acc_blank;
  logic acc_susp, acc_resume, acc_clr, acc_read;
  logic [1:0] rd_mode;
  logic ckpt, last_ckpt, susp_take;
  logic tmr_load, tmr_run, tmr_done;
  logic erase_run, vpp_fault, erase_done, prog_done, blank_done, blank_fail;
  logic set_eerr, set_perr, set_verr;

  esc_cmd_gate #(.BLK_W(BLK_W)) u_gate (
    .valid      (cmd_valid),
    .op         (cmd_op),
    .blk        (cmd_blk),
    .susp_blk   (eblk_q),
    .state      (state_q),
    .acc_erase  (acc_erase),
    .acc_prog   (acc_prog),
    .acc_nest   (acc_nest),
    .prog_hit   (prog_hit),
    .acc_blank  (acc_blank),
    .acc_susp   (acc_susp),
    .acc_resume (acc_resume),
    .acc_clr    (acc_clr),
    .acc_read   (acc_read),
    .rd_mode    (rd_mode)
  );

  assign erase_run = (state_q == ST_ERASE);
  assign vpp_fault = erase_run && !vpp_ok;

  esc_erase_seq #(.NCHK(NCHK), .SEG_CYC(SEG_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (acc_erase),
    .resume    (acc_resume),
    .run       (erase_run),
    .susp_cmd  (acc_susp),
    .ckpt      (ckpt),
    .last_ckpt (last_ckpt),
    .susp_take (susp_take)
  );

  assign tmr_load = acc_prog || acc_nest || acc_blank;
  assign tmr_run  = (state_q == ST_PROG) || (state_q == ST_BLANK) ||
                    (state_q == ST_SUSP_PROG);

  esc_op_timer #(.MAXC(MAXC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (acc_blank ? BLANK_LEN : PROG_LEN),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  assign erase_done = last_ckpt && !vpp_fault;
  assign prog_done  = tmr_done && ((state_q == ST_PROG) || (state_q == ST_SUSP_PROG));
  assign blank_done = tmr_done && (state_q == ST_BLANK);
  assign blank_fail = blank_done && !blank_q[pblk_q];

  assign set_eerr = vpp_fault || blank_fail;
  assign set_verr = vpp_fault;
  assign set_perr = prog_hit;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE: begin
        if (acc_erase)      state_n = ST_ERASE;
        else if (acc_prog)  state_n = ST_PROG;
        else if (acc_blank) state_n = ST_BLANK;
      end
      ST_ERASE: begin
        if (vpp_fault)      state_n = ST_IDLE;
        else if (last_ckpt) state_n = ST_IDLE;
        else if (susp_take) state_n = ST_SUSP;
      end
      ST_PROG, ST_BLANK: begin
        if (tmr_done) state_n = ST_IDLE;
      end
      ST_SUSP: begin
        if (acc_resume)    state_n = ST_ERASE;
        else if (acc_nest) state_n = ST_SUSP_PROG;
      end
      ST_SUSP_PROG: begin
        if (tmr_done) state_n = ST_SUSP;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eblk_q  <= '0;
      pblk_q  <= '0;
      rmode_q <= RM_ARRAY;
    end else begin
      state_q <= state_n;
      if (acc_erase) eblk_q <= cmd_blk;
      if (tmr_load)  pblk_q <= cmd_blk;
      if (acc_erase || tmr_load || acc_resume) rmode_q <= RM_STATUS;
      else if (acc_read)                       rmode_q <= rd_mode;
    end
  end

  // per-block erased flag, used by blank check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '1;
    end else begin
      if (acc_erase || acc_prog || acc_nest) blank_q[cmd_blk] <= 1'b0;
      if (erase_done)                        blank_q[eblk_q]  <= 1'b1;
    end
  end

  logic ready_w, susp_w;
  assign ready_w = (state_q == ST_IDLE) || (state_q == ST_SUSP);
  assign susp_w  = (state_q == ST_SUSP) || (state_q == ST_SUSP_PROG);

  esc_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready_w),
    .susp     (susp_w),
    .set_eerr (set_eerr),
    .set_perr (set_perr),
    .set_verr (set_verr),
    .clr      (acc_clr),
    .sr       (status_o)
  );

  assign ready_o     = status_o[SR_RDY];
  assign esusp_o     = status_o[SR_ESUS];
  assign read_mode_o = rmode_q;

  always_comb begin
    case (state_q)
      ST_ERASE, ST_SUSP:               busy_blk_o = eblk_q;
      ST_PROG, ST_BLANK, ST_SUSP_PROG: busy_blk_o = pblk_q;
      default:                         busy_blk_o = '0;
    endcase
  end

  // R3: pause entered only at a checkpoint
  a_r3_susp_only_at_ckpt: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_run && !ckpt) |=> (state_q != ST_SUSP));

  a_r4_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    acc_resume |=> (!esusp_o && !ready_o && state_q == ST_ERASE));

  a_r5_nest_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP_PROG && tmr_done) |=> (esusp_o && ready_o));

  a_r6_hit_flags_perr: assert property (@(posedge clk) disable iff (!rst_n)
    prog_hit |=> (status_o[SR_PERR] && state_q == ST_SUSP));

  a_r7_one_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_erase, acc_prog, acc_nest, prog_hit, acc_blank,
              acc_susp, acc_resume, acc_clr, acc_read}));

  a_r7_no_new_op_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP) |=> (state_q != ST_PROG && state_q != ST_BLANK));

  a_r8_resume_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUSP_PROG) |=> (state_q != ST_ERASE));

  a_r10_vpp_halts: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_fault |=> (state_q == ST_IDLE && status_o[SR_VERR] && status_o[SR_EERR]));

endmodule

// File: tb/erase_susp_ctrl_tb_top.sv
module erase_susp_ctrl_tb_top;

  localparam int NCHK  = 4;
  localparam int SEG   = 6;
  localparam int PROGC = 5;
  localparam int CHKC  = 3;
  localparam int TOT   = NCHK * SEG;

  localparam logic [3:0] C_RDA = 4'd1, C_RDS = 4'd2, C_RDI = 4'd3, C_RDQ = 4'd4;
  localparam logic [3:0] C_CLR = 4'd5, C_ERS = 4'd6, C_PRG = 4'd7, C_SUS = 4'd8;
  localparam logic [3:0] C_RES = 4'd9, C_BLK = 4'd10;

  logic       clk, rst_n, cmd_valid, vpp_ok;
  logic [3:0] cmd_op;
  logic [2:0] cmd_blk;
  logic [7:0] status;
  logic       ready, esusp;
  logic [2:0] busy_blk;
  logic [1:0] rmode;

  int n_chk = 0;
  int n_fail = 0;

  erase_susp_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_blk     (cmd_blk),
    .vpp_ok      (vpp_ok),
    .status_o    (status),
    .ready_o     (ready),
    .esusp_o     (esusp),
    .busy_blk_o  (busy_blk),
    .read_mode_o (rmode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive at a falling edge, sampled on the next rising edge
  task automatic issue(input logic [3:0] op, input logic [2:0] blk);
    cmd_op    = op;
    cmd_blk   = blk;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 4'd0;
  endtask

  // edge (counted from the erase strobe) at which a pause taken on edge k lands
  function automatic int susp_edge(input int k);
    return ((k + SEG - 1) / SEG) * SEG;
  endfunction

  function automatic int remain_edges(input int paused_at);
    return (NCHK - paused_at / SEG) * SEG;
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic run_susp(input int k, input logic [2:0] eb, input bit rnd);
    int t;
    issue(C_CLR, 3'd0);
    issue(C_ERS, eb);
    chk("R2", "erase start status", status, 8'h00);
    chk("R2", "erase busy block", busy_blk, eb);
    chk("R2", "erase read mode", rmode, 2'd1);
    step(k - 1);
    issue(C_SUS, 3'($urandom_range(0, 7)));  // R9 block ignored
    t = susp_edge(k);
    if (t >= TOT) begin
      step(TOT - k - 1);
      chk("R3", "last segment busy", ready, 1'b0);
      step(1);
      chk("R3", "final ckpt completes", status, 8'h80);
      chk("R3", "no pause at end", esusp, 1'b0);
      return;
    end
    if (t > k) begin
      step(t - k - 1);
      chk("R3", "not paused before ckpt", esusp, 1'b0);
      step(1);
    end
    chk("R3", "paused status", status, 8'hC0);
    chk("R3", "paused block", busy_blk, eb);
    if (rnd) begin
      logic [3:0] bad [5] = '{4'd0, C_ERS, C_SUS, C_BLK, 4'd15};
      for (int i = 0; i < 3; i++) begin
        issue(bad[$urandom_range(0, 4)], 3'($urandom_range(0, 7)));
        chk("R7", "illegal in pause status", status, 8'hC0);
        chk("R7", "illegal in pause block", busy_blk, eb);
      end
    end
    begin
      logic [2:0] pb;
      pb = 3'($urandom_range(0, 7));
      issue(C_PRG, pb);
      if (pb == eb) begin
        chk("R6", "program paused block", status, 8'hD0);
        chk("R6", "still paused block", busy_blk, eb);
        issue(C_CLR, 3'd0);
        chk("R12", "clear in pause", status, 8'hC0);
      end else begin
        chk("R5", "nested program status", status, 8'h40);
        chk("R5", "nested program block", busy_blk, pb);
        issue(C_RES, eb);
        step(PROGC - 2);
        chk("R8", "resume ignored during program", status, 8'h40);
        step(1);
        chk("R5", "back to paused", status, 8'hC0);
        chk("R8", "still paused after program", busy_blk, eb);
      end
    end
    issue(C_RDA, eb);
    chk("R6", "read of paused block refused", rmode, 2'd1);
    issue(C_RDA, eb ^ 3'd1);
    chk("R6", "read of other block", rmode, 2'd0);
    issue(C_RES, 3'($urandom_range(0, 7)));
    chk("R4", "resume clears bits", status, 8'h00);
    step(remain_edges(t) - 1);
    chk("R4", "resumed erase busy", ready, 1'b0);
    step(1);
    chk("R4", "resumed erase done", status, 8'h80);
    chk("R4", "idle block", busy_blk, 3'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 4'd0; cmd_blk = 3'd0; vpp_ok = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1", "reset status", status, 8'h80);
    chk("R1", "reset ready", ready, 1'b1);
    chk("R1", "reset paused", esusp, 1'b0);
    chk("R1", "reset block", busy_blk, 3'd0);
    chk("R1", "reset read mode", rmode, 2'd0);

    issue(C_RDI, 3'd0);
    chk("R2", "read id mode", rmode, 2'd2);
    issue(C_RDQ, 3'd0);
    chk("R2", "read query mode", rmode, 2'd3);

    // R11 blank checks on untouched, programmed and erased blocks
    issue(C_BLK, 3'd6);
    chk("R11", "blank busy", busy_blk, 3'd6);
    step(CHKC - 1);
    chk("R11", "blank running", ready, 1'b0);
    step(1);
    chk("R11", "untouched block blank", status, 8'h80);
    issue(C_PRG, 3'd6);
    step(PROGC - 1);
    chk("R5", "idle program running", ready, 1'b0);
    step(1);
    chk("R5", "idle program done", status, 8'h80);
    issue(C_BLK, 3'd6);
    step(CHKC);
    chk("R11", "programmed block not blank", status, 8'hA0);
    issue(C_RDS, 3'd0);
    chk("R12", "error sticky", status, 8'hA0);
    issue(C_CLR, 3'd0);
    chk("R12", "clear", status, 8'h80);

    // R2/R7 full erase, program during erase ignored
    issue(C_ERS, 3'd6);
    step(2);
    issue(C_PRG, 3'd5);
    chk("R7", "program during erase ignored", busy_blk, 3'd6);
    step(TOT - 4);
    chk("R2", "erase near end", ready, 1'b0);
    step(1);
    chk("R2", "erase done", status, 8'h80);
    chk("R2", "erase done block", busy_blk, 3'd0);
    issue(C_BLK, 3'd6);
    step(CHKC);
    chk("R11", "erased block blank", status, 8'h80);

    // R10 supply loss
    issue(C_ERS, 3'd2);
    step(3);
    vpp_ok = 1'b0;
    step(1);
    chk("R10", "halted status", status, 8'hA8);
    vpp_ok = 1'b1;
    issue(C_CLR, 3'd0);
    issue(C_BLK, 3'd2);
    step(CHKC);
    chk("R10", "halted block not blank", status, 8'hA0);

    // R3 directed offsets, then random ones
    run_susp(1, 3'd4, 1'b1);
    run_susp(SEG, 3'd1, 1'b1);
    run_susp(SEG + 1, 3'd7, 1'b1);
    run_susp(TOT - SEG + 1, 3'd0, 1'b0);
    for (int n = 0; n < 8; n++)
      run_susp($urandom_range(1, TOT - 1), 3'($urandom_range(0, 7)), 1'b1);

    // R13 reset while paused
    issue(C_ERS, 3'd1);
    step(SEG - 1);
    issue(C_SUS, 3'd5);
    chk("R3", "pause on ckpt edge", esusp, 1'b1);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R13", "reset from pause status", status, 8'h80);
    chk("R13", "reset from pause block", busy_blk, 3'd0);
    chk("R13", "reset from pause mode", rmode, 2'd0);

    report();
    $finish;
  end

endmodule